// File: doc/BRIEF.md
# Glitch-Free CPU and PCI Clock Stop Controller

This block takes the internal CPU clock and produces two gated clock groups: a set of CPU clock outputs, and a set of PCI clock outputs at a fixed 33.3 MHz that is derived from the CPU clock. A rate select input says whether the CPU clock runs at 100 MHz or 66.6 MHz. The block then divides the CPU clock by three or by two to get the internal PCI clock. A new rate is taken up only at a PCI period boundary. The fast-mode divider uses both CPU clock edges, so the PCI clock keeps a 50 % duty cycle.

Two asynchronous active-low stop requests control the groups, one for the CPU outputs and one for the gated PCI outputs. Each request passes through its own synchronizer clocked by the falling CPU edge. It then loads an enable register, and that register is allowed to change only while the clock it gates is low. A gated output therefore always stops low and always restarts with a full high phase. One free-running PCI output and one early PCI output ignore the PCI stop request. A power-down indicator is synchronized in the same way. While it is asserted, both enable registers are frozen, so the stop requests have no effect.

Top module: `clock_stop_ctrl`

## Requirements
- R1: While reset is asserted, every output (CPU, gated PCI, free-running PCI and early PCI) is low.
- R2: With the rate select high (fast, divide by 3), each PCI clock period lasts 3 CPU cycles and is high for 1.5 CPU cycles.
- R3: With the rate select low (slow, divide by 2), each PCI clock period lasts 2 CPU cycles and is high for 1 CPU cycle.
- R4: A change of the rate select takes effect only at a PCI period boundary. Every PCI period is one complete fast period or one complete slow period, never a mixture.
- R5: After the CPU stop request goes low (stop), all CPU outputs are held low within 4 CPU cycles and stay low.
- R6: After the CPU stop request goes high (run), the CPU outputs produce a rising edge within 4 CPU cycles.
- R7: Every high pulse on a gated output is full width: half a CPU cycle on the CPU outputs, and the current mode's PCI high time on the PCI outputs. An enable changes only while its source clock is low.
- R8: After the PCI stop request goes low (stop), the gated PCI outputs are held low within the synchronizer delay plus one PCI period. After it goes high (run), they restart within the same bound.
- R9: The free-running PCI output and the early PCI output keep toggling while the PCI stop request is low.
- R10: The two groups are independent. A CPU stop leaves the PCI outputs toggling, and a PCI stop leaves the CPU outputs toggling.
- R11: While the power-down indicator is high, changes on both stop requests have no effect and the outputs keep their run or stop state. Requests still pending when power-down ends are then applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Internal CPU clock (source of all outputs) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_fast | input | 1 | Rate select: 1 = 100 MHz CPU clock (divide by 3), 0 = 66.6 MHz (divide by 2) |
| cpu_stop_n | input | 1 | Asynchronous CPU group stop request, active low |
| pci_stop_n | input | 1 | Asynchronous gated PCI group stop request, active low |
| pwr_dn | input | 1 | Asynchronous power-down indicator, active high; freezes both gates |
| cpu_clk_o | output | N_CPU (3) | Gated CPU clock outputs |
| pci_clk_o | output | N_PCI (5) | Gated PCI clock outputs |
| pci_free_o | output | 1 | Free-running PCI clock |
| pci_early_o | output | 1 | Early PCI clock, never gated |

## Verification
A wrong divider count or a rate captured in the middle of a period shows up on the very next PCI pulse as a high time or a period that matches neither mode. An enable register that changes while its clock is high shows up as a runt pulse, shorter than the expected half period, on the first pulse after a stop or a run edge. A synchronizer that is too deep, or a gate that misses its load window, shows up as stop or start edges later than the latency bound. A gate that is not frozen in power-down shows up as a group that stops within a few cycles of a request that should have been ignored.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } cpu_rate_e;

  localparam int unsigned DIV_CNT_W = 2;

  // Final count value of one PCI period for a given CPU rate.
  function automatic logic [DIV_CNT_W-1:0] div_last(cpu_rate_e rate);
    return (rate == RATE_FAST) ? DIV_CNT_W'(2) : DIV_CNT_W'(1);
  endfunction

endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] pipe_q;

  // Falling-edge stages: the result is stable across the whole low phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/pci_divider.sv
module pci_divider
  import clkstop_pkg::*;
(
  input  logic cpu_clk,
  input  logic rst_n,
  input  logic sel_fast,
  output logic pci_clk,
  output logic pci_low_win
);

  cpu_rate_e              rate_q;
  logic [DIV_CNT_W-1:0]   cnt_q;
  logic [DIV_CNT_W-1:0]   last_cnt;
  logic                   pci_wrap;
  logic                   lead_q;
  logic                   trail_q;

  assign last_cnt = div_last(rate_q);
  assign pci_wrap = (cnt_q == last_cnt);

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= RATE_SLOW;
      lead_q <= 1'b0;
    end else if (pci_wrap) begin
      cnt_q  <= '0;
      rate_q <= cpu_rate_e'(sel_fast);
      lead_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DIV_CNT_W'(1);
      lead_q <= 1'b0;
    end
  end

  // Half-cycle extension of the high phase in divide-by-3 mode.
  always_ff @(negedge cpu_clk or negedge rst_n) begin
    if (!rst_n) trail_q <= 1'b0;
    else        trail_q <= lead_q & (rate_q == RATE_FAST);
  end

  assign pci_clk     = lead_q | trail_q;
  assign pci_low_win = pci_wrap;

  assert_wrap_spacing_R2: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    pci_wrap |=> !pci_wrap);

  assert_rate_at_boundary_R4: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (rate_q != $past(rate_q)) |-> $past(pci_wrap));

  assert_window_is_low_R7: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    pci_low_win |-> !pci_clk);

endmodule

// File: rtl/gate_bank.sv
module gate_bank #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_clk,
  input  logic             load,
  input  logic             run_req,
  output logic             en_o,
  output logic [WIDTH-1:0] gclk_o
);

  logic en_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= 1'b0;
    else if (load) en_q <= run_req;
  end

  assign en_o = en_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_out
    assign gclk_o[g] = src_clk & en_q;
  end

  assert_load_gated_R11: assert property (@(negedge clk) disable iff (!rst_n)
    !load |=> $stable(en_q));

endmodule

// File: rtl/clock_stop_ctrl.sv
module clock_stop_ctrl #(
  parameter int unsigned N_CPU       = 3,
  parameter int unsigned N_PCI       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             cpu_clk,
  input  logic             rst_n,
  input  logic             sel_fast,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwr_dn,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic             pci_free_o,
  output logic             pci_early_o
);

  logic cpu_run_sync;
  logic pci_run_sync;
  logic pd_sync;
  logic pci_int;
  logic pci_low_win;
  logic cpu_load;
  logic pci_load;
  logic cpu_en;
  logic pci_en;

  stop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cpu_sync (
    .clk(cpu_clk), .rst_n(rst_n), .async_i(cpu_stop_n), .sync_o(cpu_run_sync));

  stop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pci_sync (
    .clk(cpu_clk), .rst_n(rst_n), .async_i(pci_stop_n), .sync_o(pci_run_sync));

  stop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_sync (
    .clk(cpu_clk), .rst_n(rst_n), .async_i(pwr_dn), .sync_o(pd_sync));

  pci_divider u_div (
    .cpu_clk(cpu_clk), .rst_n(rst_n), .sel_fast(sel_fast),
    .pci_clk(pci_int), .pci_low_win(pci_low_win));

  assign cpu_load = !pd_sync;
  assign pci_load = pci_low_win & !pd_sync;

  gate_bank #(.WIDTH(N_CPU)) u_cpu_gate (
    .clk(cpu_clk), .rst_n(rst_n), .src_clk(cpu_clk), .load(cpu_load),
    .run_req(cpu_run_sync), .en_o(cpu_en), .gclk_o(cpu_clk_o));

  gate_bank #(.WIDTH(N_PCI)) u_pci_gate (
    .clk(cpu_clk), .rst_n(rst_n), .src_clk(pci_int), .load(pci_load),
    .run_req(pci_run_sync), .en_o(pci_en), .gclk_o(pci_clk_o));

  assign pci_free_o  = pci_int;
  assign pci_early_o = pci_int;

  assert_cpu_follow_R5: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    !pd_sync |=> (cpu_en == $past(cpu_run_sync)));

  assert_pci_en_low_phase_R7: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    !$stable(pci_en) |-> !$past(pci_int));

  assert_pd_freeze_R11: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    pd_sync |=> ($stable(cpu_en) && $stable(pci_en)));

endmodule

// File: tb/test_clock_stop_ctrl.sv
`timescale 1ns/1ps
module test_clock_stop_ctrl;

  localparam int NC = 3;
  localparam int NP = 5;
  localparam int NO = NC + NP + 2;

  logic cpu_clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_fast = 1'b1;
  logic cpu_stop_n = 1'b1;
  logic pci_stop_n = 1'b1;
  logic pwr_dn = 1'b0;
  logic [NC-1:0] cpu_clk_o;
  logic [NP-1:0] pci_clk_o;
  logic pci_free_o, pci_early_o;
  logic [NO-1:0] all_out;

  always #5 cpu_clk = ~cpu_clk;

  clock_stop_ctrl #(.N_CPU(NC), .N_PCI(NP), .SYNC_STAGES(2)) i_clock_stop_ctrl (
    .cpu_clk(cpu_clk), .rst_n(rst_n), .sel_fast(sel_fast), .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n), .pwr_dn(pwr_dn), .cpu_clk_o(cpu_clk_o),
    .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o), .pci_early_o(pci_early_o));

  assign all_out = {pci_early_o, pci_free_o, pci_clk_o, cpu_clk_o};

  // ---------------- pulse shape monitor (R2, R3, R4, R7) ----------------
  int      pw_checks = 0, pw_fails = 0;
  int      rises [NO];
  realtime t_rise[NO];
  logic [NO-1:0] prev_out = '0;
  bit      settled = 1'b0;
  real     exp_hi = 15.0;

  function automatic bit near(real a, real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic pw_chk(input bit ok, input string req, input string what, input real act, input real exp);
    pw_checks++;
    if (!ok) begin
      pw_fails++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f at %0t", req, what, act, exp, $realtime);
    end
  endtask

  initial for (int i = 0; i < NO; i++) begin rises[i] = 0; t_rise[i] = -1.0; end

  always @(all_out) begin
    for (int i = 0; i < NO; i++) begin
      if (prev_out[i] === 1'b0 && all_out[i] === 1'b1) begin
        rises[i]++;
        if (i == NC + NP && t_rise[i] >= 0.0) begin
          real per;
          per = $realtime - t_rise[i];
          pw_chk(near(per, 20.0) || near(per, 30.0), "R4", "PCI period shape", per, 2.0 * exp_hi);
          if (settled)
            pw_chk(near(per, 2.0 * exp_hi), exp_hi > 12.0 ? "R2" : "R3", "PCI period", per, 2.0 * exp_hi);
        end
        t_rise[i] = $realtime;
      end else if (prev_out[i] === 1'b1 && all_out[i] === 1'b0 && t_rise[i] >= 0.0) begin
        real w;
        w = $realtime - t_rise[i];
        if (i < NC) pw_chk(near(w, 5.0), "R7", "CPU high width", w, 5.0);
        else begin
          pw_chk(near(w, 10.0) || near(w, 15.0), "R7", "PCI high width", w, exp_hi);
          if (settled)
            pw_chk(near(w, exp_hi), exp_hi > 12.0 ? "R2" : "R3", "PCI high width", w, exp_hi);
        end
      end
    end
    prev_out = all_out;
  end

  function automatic int grp_sum(int g);
    int s = 0;
    for (int i = 0; i < NO; i++) begin
      if (g == 0 && i < NC) s += rises[i];
      if (g == 1 && i >= NC && i < NC + NP) s += rises[i];
      if (g == 2 && i >= NC + NP) s += rises[i];
    end
    return s;
  endfunction

  // ---------------- scoreboard ----------------
  typedef struct {
    int    kind;   // 0 activity window, 1 reset level
    int    grp;    // 0 CPU, 1 gated PCI, 2 free+early PCI
    bit    run;
    int    dly;
    int    len;
    string req;
  } obs_t;

  obs_t sbq[$];
  bit   mon_busy = 1'b0;
  int   sb_checks = 0, sb_fails = 0;

  task automatic sb_chk(input bit ok, input string req, input string what, input int act, input int exp);
    sb_checks++;
    if (!ok) begin
      sb_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $realtime);
    end
  endtask

  initial begin
    forever begin
      while (sbq.size() == 0) @(negedge cpu_clk);
      mon_busy = 1'b1;
      begin
        obs_t it;
        int snap, d;
        it = sbq.pop_front();
        if (it.kind == 1) begin
          @(posedge cpu_clk); #1;
          sb_chk(all_out === '0, it.req, "outputs in reset", int'(all_out), 0);
        end else begin
          repeat (it.dly) @(posedge cpu_clk);
          #1;
          snap = grp_sum(it.grp);
          repeat (it.len) @(posedge cpu_clk);
          #1;
          d = grp_sum(it.grp) - snap;
          sb_chk((d > 0) == it.run, it.req, $sformatf("group %0d toggling", it.grp), d > 0, it.run);
          if (!it.run && it.grp == 0)
            sb_chk(cpu_clk_o === '0, it.req, "CPU outputs held low", int'(cpu_clk_o), 0);
          if (!it.run && it.grp == 1)
            sb_chk(pci_clk_o === '0, it.req, "PCI outputs held low", int'(pci_clk_o), 0);
        end
      end
      mon_busy = 1'b0;
    end
  end

  task automatic expect_obs(input int kind, input int grp, input bit run, input int dly, input int len, input string req);
    obs_t it;
    it.kind = kind; it.grp = grp; it.run = run; it.dly = dly; it.len = len; it.req = req;
    sbq.push_back(it);
    while (sbq.size() != 0 || mon_busy) @(negedge cpu_clk);
  endtask

  task automatic at_edge();
    @(posedge cpu_clk); #2;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", sb_checks + pw_checks, sb_fails + pw_fails);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (50000) @(posedge cpu_clk);
    $display("FAIL watchdog R5: actual run still active, expected done");
    sb_fails++; sb_checks++;
    summary();
    $finish;
  end

  task automatic set_rate(input bit fast);
    settled = 1'b0;
    @(posedge cpu_clk); #3;
    sel_fast = fast;
    repeat (10) @(posedge cpu_clk);
    exp_hi = fast ? 15.0 : 10.0;
    settled = 1'b1;
  endtask

  task automatic stop_start_cycle(input string rate_tag);
    // CPU stop: PCI groups keep going
    at_edge(); cpu_stop_n = 1'b0;
    expect_obs(0, 0, 1'b0, 4, 8, "R5");
    expect_obs(0, 1, 1'b1, 0, 8, "R10");
    expect_obs(0, 2, 1'b1, 0, 8, "R10");
    at_edge(); cpu_stop_n = 1'b1;
    expect_obs(0, 0, 1'b1, 0, 4, "R6");
    // PCI stop: free/early and CPU keep going
    at_edge(); pci_stop_n = 1'b0;
    expect_obs(0, 1, 1'b0, 6, 9, "R8");
    expect_obs(0, 2, 1'b1, 0, 8, "R9");
    expect_obs(0, 0, 1'b1, 0, 4, "R10");
    at_edge(); pci_stop_n = 1'b1;
    expect_obs(0, 1, 1'b1, 0, 7, "R8");
    repeat (6) @(posedge cpu_clk);
    $display("stop/start cycle done in %s mode", rate_tag);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge cpu_clk);
    expect_obs(1, 0, 1'b0, 0, 0, "R1");
    at_edge(); rst_n = 1'b1;
    repeat (12) @(posedge cpu_clk);
    exp_hi = 15.0; settled = 1'b1;
    expect_obs(0, 2, 1'b1, 0, 12, "R2");
    expect_obs(0, 0, 1'b1, 0, 4, "R6");
    stop_start_cycle("fast");

    set_rate(1'b0);
    expect_obs(0, 2, 1'b1, 0, 12, "R3");
    stop_start_cycle("slow");

    set_rate(1'b1);
    expect_obs(0, 1, 1'b1, 0, 12, "R4");
    settled = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge cpu_clk); #(1 + 2 * k);
      sel_fast = ~sel_fast;
      repeat (3 + k) @(posedge cpu_clk);
    end
    sel_fast = 1'b1;
    repeat (10) @(posedge cpu_clk);
    exp_hi = 15.0; settled = 1'b1;
    expect_obs(0, 1, 1'b1, 0, 9, "R4");

    // power-down freezes both gates
    at_edge(); pwr_dn = 1'b1;
    repeat (5) @(posedge cpu_clk);
    at_edge(); cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
    expect_obs(0, 0, 1'b1, 4, 10, "R11");
    expect_obs(0, 1, 1'b1, 0, 10, "R11");
    at_edge(); pwr_dn = 1'b0;
    expect_obs(0, 0, 1'b0, 6, 8, "R11");
    expect_obs(0, 1, 1'b0, 0, 9, "R11");
    at_edge(); cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    expect_obs(0, 0, 1'b1, 0, 4, "R6");
    expect_obs(0, 1, 1'b1, 0, 7, "R8");
    repeat (10) @(posedge cpu_clk);
    summary();
    $finish;
  end

endmodule